// File: doc/BRIEF.md
# Guarded Comparator Selection Register

This block is an 8-bit control register that sits in front of an analog comparator. Software writes it over a simple bus: a write strobe, eight data bits and an eight-bit per-bit write mask. A mask of all ones writes the whole byte, and a mask with one bit set writes a single bit. The register produces three controls: a one-hot code that picks one of four comparator inputs, a two-bit code that picks the reference source, and an enable for the comparator's pin output.

Both selection fields are protected. Once a field holds a non-zero value, it takes a different non-zero value only after it has first been cleared to zero. The input field also refuses any code with more than one bit set. The reference field refuses code 11. Each field is checked on its own, so a refused field does not stop the other fields of the same byte from being written.

Any accepted change to a selection starts a settle timer, sized for 300 ns at the configured clock frequency. While that timer runs, `ready` is low and the gated pin output is forced low. Otherwise the pin output is the comparator result bit of the selected input, qualified by the output enable.

Top module: `cmp_select_reg`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0x00, `in_sel`, `ref_sel` and `pin_oe` are 0, `ready` is 1 and `pin_out` is 0.
- R2: `rd_data` shows the register state: bit 7 always reads 0, bit 6 is the output enable, bits 5:4 are the reference code and bits 3:0 are the input code.
- R3: A write takes effect at the clock edge where `wr_en` is 1. Only the data bits whose `wr_mask` bit is 1 are written; every other bit keeps its value. With `wr_en` at 0, nothing changes.
- R4: Reference code 00 means no reference, 01 means the external reference and 10 means the internal converter-derived reference. A write that would make the field 11 is ignored and the field keeps its old value.
- R5: When the reference field is non-zero, a write that would make it a different non-zero value is ignored. A write that would make it 00 is always accepted.
- R6: Input code 0000 means no input; 0001, 0010, 0100 and 1000 select inputs 0 to 3. A write that would make the field hold more than one set bit is ignored.
- R7: When the input field is non-zero, a write that would make it a different non-zero value is ignored. A write that would make it 0000 is always accepted.
- R8: Within one write, the input field, the reference field and the enable bit are judged separately. A refused field does not block the others.
- R9: When either selection field takes a new value, `ready` goes low for exactly SETTLE = ceil(SETTLE_NS*CLK_MHZ/1000) cycles (38 by default) and then goes high. A further accepted change restarts the count. Rewriting the same value, or changing only the enable bit, does not restart it.
- R10: `pin_out` equals the `cmp_res` bit of the selected input when the enable bit is 1 and `ready` is 1. It is 0 when the enable is 0, when `ready` is 0, or when no input is selected. It follows `cmp_res` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write mask; 1 means the bit is written |
| rd_data | output | 8 | Register read value |
| in_sel | output | 4 | One-hot comparator input selection |
| ref_sel | output | 2 | Reference source code |
| pin_oe | output | 1 | Pin output enable |
| cmp_res | input | 4 | Digital comparator results, one bit per input |
| pin_out | output | 1 | Gated comparator pin output |
| ready | output | 1 | High once the current selection has settled |

## Verification
If a guard has accepted a write it should have refused, the bad state shows on `rd_data` and on the select outputs in the very next cycle, and the reference model flags it at once. A miscounting settle timer shows up as `ready` rising one or more cycles too early or too late, measured from the edge of the accepted write. That error also shows on `pin_out`, which would be released or held at the wrong time. Long random write sequences, mixing masked single-bit writes with byte writes, reach restarts in the middle of a settle period and refusals of both fields within one write, on top of the directed cases.

// File: rtl/cmp_sel_pkg.sv
// Package: shared field positions, reference codes and the settle-length
// helper for the guarded comparator selection register.
package cmp_sel_pkg;
    localparam int IN_W    = 4;
    localparam int REF_W   = 2;
    localparam int IN_LSB  = 0;
    localparam int REF_LSB = 4;
    localparam int OE_BIT  = 6;

    typedef enum logic [REF_W-1:0] {
        REF_NONE = 2'b00,
        REF_EXT  = 2'b01,
        REF_INT  = 2'b10,
        REF_BAD  = 2'b11
    } ref_code_e;

    // Number of clock cycles covering ns nanoseconds at mhz MHz, rounded up.
    function automatic int settle_cycles(input int mhz, input int ns);
        return (ns * mhz + 999) / 1000;
    endfunction
endpackage

// File: rtl/cmp_sel_field_guard.sv
// Module: cmp_sel_field_guard
// Holds one guarded selection field. A masked write builds a candidate value.
// The candidate is accepted when it differs from the stored value and either
// is zero, or lands on an empty field and passes the shape check. With
// ONEHOT_ONLY set, the shape check accepts at most one set bit.
// Assumes: synchronous active-low reset to RST_VAL; changed_o is a
// same-cycle pulse that qualifies the update at the next edge.
module cmp_sel_field_guard #(
    parameter int             W           = 4,
    parameter bit             ONEHOT_ONLY = 1'b1,
    parameter logic [W-1:0]   RST_VAL     = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] value_o,
    output logic         changed_o
);
    logic [W-1:0] value_q;
    logic [W-1:0] cand;
    logic         shape_ok;
    logic         seen_q;

    // Merge masked write bits into the stored value.
    always_comb cand = (value_q & ~wr_mask) | (wr_data & wr_mask);

    // Pick the shape rule for this field.
    generate
        if (ONEHOT_ONLY) begin : g_onehot
            assign shape_ok = ((cand & (cand - W'(1))) == '0);
        end else begin : g_any
            assign shape_ok = 1'b1;
        end
    endgenerate

    // Decide whether the candidate may replace the stored value.
    always_comb begin
        changed_o = 1'b0;
        if (wr_en && (cand != value_q)) begin
            if (cand == '0)
                changed_o = 1'b1;
            else if ((value_q == '0) && shape_ok)
                changed_o = 1'b1;
        end
    end

    // Field storage.
    always_ff @(posedge clk) begin
        if (!rst_n)         value_q <= RST_VAL;
        else if (changed_o) value_q <= cand;
    end

    // Marks that at least one clock edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign value_o = value_q;

    // A non-zero value may only be left by going to zero (R5, R7).
    assert_sticky_nonzero_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(value_q) != '0)) |-> ((value_q == '0) || (value_q == $past(value_q))));

    generate
        if (ONEHOT_ONLY) begin : g_chk
            // Stored value never has more than one set bit (R4, R6).
            assert_onehot_field_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(value_q));
        end
    endgenerate
endmodule

// File: rtl/cmp_sel_settle_timer.sv
// Module: cmp_sel_settle_timer
// Down-counter that loads CYCLES on start and counts to zero; ready_o is
// high only at zero. A start during a running count reloads it.
// Assumes: CYCLES >= 1; synchronous active-low reset leaves ready_o high.
module cmp_sel_settle_timer #(
    parameter int CYCLES = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Reload on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    assign ready_o = (cnt_q == '0);

    // A start always clears ready on the next cycle (R9).
    assert_start_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready_o);
    // Once ready, it stays ready until the next start (R9).
    assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start) |=> ready_o);
endmodule

// File: rtl/cmp_sel_pin_gate.sv
// Module: cmp_sel_pin_gate
// Selects the comparator result named by the one-hot input code and gates it
// with the enable and settle-ready signals. Purely combinational.
// Assumes: sel is one-hot or zero.
module cmp_sel_pin_gate #(
    parameter int N = 4
) (
    input  logic         oe,
    input  logic         ready,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] res,
    output logic         pin
);
    logic [N-1:0] hit;

    // Per-input AND of select and result.
    generate
        for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = sel[i] & res[i];
        end
    endgenerate

    // Gate the selected result.
    always_comb pin = oe & ready & (|hit);
endmodule

// File: rtl/cmp_select_reg.sv
// Module: cmp_select_reg
// Top of the guarded comparator selection register. It holds the output
// enable bit directly and uses two field guards for the input and reference
// codes. It drives a settle timer from accepted selection changes and gates
// the pin output.
// Assumes: synchronous active-low reset; CLK_MHZ is the clock frequency.
module cmp_select_reg
    import cmp_sel_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_NS = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [7:0] wr_mask,
    output logic [7:0] rd_data,
    output logic [3:0] in_sel,
    output logic [1:0] ref_sel,
    output logic       pin_oe,
    input  logic [3:0] cmp_res,
    output logic       pin_out,
    output logic       ready
);
    localparam int SETTLE = settle_cycles(CLK_MHZ, SETTLE_NS);

    logic oe_q;
    logic in_chg;
    logic ref_chg;

    // Input selection field: one-hot, guarded.
    cmp_sel_field_guard #(.W(IN_W), .ONEHOT_ONLY(1'b1), .RST_VAL('0)) u_in_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data[IN_LSB +: IN_W]),
        .wr_mask  (wr_mask[IN_LSB +: IN_W]),
        .value_o  (in_sel),
        .changed_o(in_chg)
    );

    // Reference field: the one-hot rule also refuses code 11.
    cmp_sel_field_guard #(.W(REF_W), .ONEHOT_ONLY(1'b1), .RST_VAL(REF_NONE)) u_ref_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data[REF_LSB +: REF_W]),
        .wr_mask  (wr_mask[REF_LSB +: REF_W]),
        .value_o  (ref_sel),
        .changed_o(ref_chg)
    );

    // Output enable bit: unguarded, masked write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    oe_q <= 1'b0;
        else if (wr_en && wr_mask[OE_BIT]) oe_q <= wr_data[OE_BIT];
    end

    // Settle timer restarted by any accepted selection change.
    cmp_sel_settle_timer #(.CYCLES(SETTLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (in_chg | ref_chg),
        .ready_o(ready)
    );

    // Gated pin output.
    cmp_sel_pin_gate #(.N(IN_W)) u_gate (
        .oe   (oe_q),
        .ready(ready),
        .sel  (in_sel),
        .res  (cmp_res),
        .pin  (pin_out)
    );

    assign pin_oe  = oe_q;

    // Read-back assembly; bit 7 reads zero.
    always_comb rd_data = {1'b0, oe_q, ref_sel, in_sel};

    // Pin stays low unless enabled, settled and an input is selected (R10).
    assert_pin_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_oe || !ready || (in_sel == '0)) |-> !pin_out);
    // A disabled write leaves the register unchanged (R3).
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: tb/cmp_select_reg_tb_top.sv
`timescale 1ns/1ps
module cmp_select_reg_tb_top;
    localparam int SETTLE = (300 * 125 + 999) / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] wr_mask = '0;
    logic [3:0] cmp_res = '0;
    logic [7:0] rd_data;
    logic [3:0] in_sel;
    logic [1:0] ref_sel;
    logic       pin_oe;
    logic       pin_out;
    logic       ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [3:0] m_in;
    logic [1:0] m_ref;
    logic       m_oe;
    int         m_cnt;

    always #4 clk = ~clk;

    cmp_select_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_data(rd_data), .in_sel(in_sel),
        .ref_sel(ref_sel), .pin_oe(pin_oe), .cmp_res(cmp_res),
        .pin_out(pin_out), .ready(ready)
    );

    function automatic logic [3:0] guard(input logic [3:0] cur, input logic [3:0] cand);
        if (cand == cur) return cur;
        if (cand == 4'd0) return 4'd0;
        if (cur != 4'd0) return cur;
        if ($countones(cand) != 1) return cur;
        return cand;
    endfunction

    function automatic logic exp_pin();
        return m_oe && (m_cnt == 0) && ((m_in & cmp_res) != 4'd0);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 rd_data", rd_data, {1'b0, m_oe, m_ref, m_in});
        chk("R9 ready", {7'd0, ready}, {7'd0, m_cnt == 0});
        chk("R10 pin_out", {7'd0, pin_out}, {7'd0, exp_pin()});
    endtask

    // One cycle: drive at negedge, update model, compare at next negedge.
    task automatic step(input logic en, input logic [7:0] d, input logic [7:0] m);
        logic [3:0] ci;
        logic [1:0] cr;
        logic [3:0] ni;
        logic [3:0] nr;
        wr_en = en; wr_data = d; wr_mask = m;
        ci = (m_in & ~m[3:0]) | (d[3:0] & m[3:0]);
        cr = (m_ref & ~m[5:4]) | (d[5:4] & m[5:4]);
        if (en) begin
            ni = guard(m_in, ci);
            nr = guard({2'b00, m_ref}, {2'b00, cr});
            if (ni != m_in || nr[1:0] != m_ref) m_cnt = SETTLE;
            else if (m_cnt > 0) m_cnt--;
            m_in = ni; m_ref = nr[1:0];
            if (m[6]) m_oe = d[6];
        end else if (m_cnt > 0) m_cnt--;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_in = 0; m_ref = 0; m_oe = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 ready", {7'd0, ready}, 8'd1);
        chk("R1 pin_out", {7'd0, pin_out}, 8'd0);
        chk("R1 selects", {1'b0, pin_oe, ref_sel, in_sel}, 8'h00);

        // R6: select input 0, then R9 settle length
        step(1'b1, 8'h01, 8'hFF);
        chk("R6 in_sel input0", {4'd0, in_sel}, 8'h01);
        chk("R9 ready low after change", {7'd0, ready}, 8'd0);
        idle(SETTLE - 1);
        chk("R9 still low at SETTLE-1", {7'd0, ready}, 8'd0);
        idle(1);
        chk("R9 high at SETTLE", {7'd0, ready}, 8'd1);
        // R7: nonzero to nonzero refused
        step(1'b1, 8'h02, 8'hFF);
        chk("R7 refused", rd_data, 8'h01);
        chk("R9 no restart on refusal", {7'd0, ready}, 8'd1);
        step(1'b1, 8'h00, 8'h0F);
        chk("R7 clear accepted", rd_data, 8'h00);
        // R6: multi-bit refused
        step(1'b1, 8'h06, 8'hFF);
        chk("R6 multibit refused", rd_data, 8'h00);
        // R4/R5 reference codes
        step(1'b1, 8'h10, 8'hFF);
        chk("R4 ext ref", {6'd0, ref_sel}, 8'h01);
        step(1'b1, 8'h20, 8'hFF);
        chk("R5 nonzero swap refused", {6'd0, ref_sel}, 8'h01);
        step(1'b1, 8'h00, 8'h30);
        step(1'b1, 8'h30, 8'hFF);
        chk("R4 code 11 refused", {6'd0, ref_sel}, 8'h00);
        step(1'b1, 8'h20, 8'h30);
        chk("R4 internal ref", {6'd0, ref_sel}, 8'h02);
        // R8: ref refused, input and oe accepted in one byte
        step(1'b1, 8'h54, 8'hFF);
        chk("R8 independent fields", rd_data, 8'h64);
        // R3: masked single-bit write, and disabled write
        step(1'b0, 8'hFF, 8'hFF);
        chk("R3 wr_en low ignored", rd_data, 8'h64);
        step(1'b1, 8'h00, 8'h40);
        chk("R3 single bit clear oe", rd_data, 8'h24);
        step(1'b1, 8'hC0, 8'h80);
        chk("R2 bit7 reads zero", rd_data, 8'h24);
        // R10: pin follows input 2 once enabled and settled
        step(1'b1, 8'h40, 8'h40);
        idle(SETTLE);
        cmp_res = 4'b0100; #1;
        chk("R10 pin follows", {7'd0, pin_out}, 8'd1);
        cmp_res = 4'b1011; #1;
        chk("R10 pin other inputs", {7'd0, pin_out}, 8'd0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] d;
            logic [7:0] m;
            int r;
            r = $urandom_range(0, 9);
            case (r)
                0, 1: d = 8'h00;
                2, 3: d = {1'b0, 1'($urandom), 2'($urandom_range(0, 2)), 4'(1 << $urandom_range(0, 3))};
                default: d = 8'($urandom);
            endcase
            m = ($urandom_range(0, 2) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'hFF;
            cmp_res = 4'($urandom);
            step(1'($urandom_range(0, 3) != 0), d, m);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule